// File: doc/BRIEF.md
# Packed Saturating Signed Subtractor

This block subtracts one packed vector of signed integers from another, lane by lane. Each lane clamps to its own signed range rather than wrapping. One datapath serves two lane sizes (8-bit and 16-bit) and two operand widths (64-bit and 128-bit). Two instruction-level bits select the form. Bit 0 of the opcode byte selects the lane size: 0xE8 gives byte lanes and 0xE9 gives word lanes. A flag that reports whether the 0x66 operand-size prefix is present selects the 128-bit width. Flags and exceptions are never produced.

The difference is formed in a single cycle of logic and held in one output register. Both the input side and the output side use a valid/ready handshake. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the result and its saturation bits are held unchanged and no new operation is accepted. A per-byte saturation vector reports which lanes were clamped, so that tests can observe clamping.

Top module: `vsub_sat`

## Requirements
- R1: In byte mode, an in-range lane gives result byte = first byte minus second byte (two's complement), written in the same byte position.
- R2: In byte mode, a lane difference greater than +127 yields 0x7F.
- R3: In byte mode, a lane difference less than -128 yields 0x80.
- R4: In word mode, each 16-bit lane gives the exact difference when it is in range, 0x7FFF above +32767 and 0x8000 below -32768.
- R5: `in_opc_lsb` = 0 (opcode 0xE8) selects byte lanes and `in_opc_lsb` = 1 (opcode 0xE9) selects word lanes. `in_pfx_wide` = 1 (prefix 0x66 present) selects 128-bit operation with 16 byte lanes or 8 word lanes. `in_pfx_wide` = 0 selects 64-bit operation with 8 byte lanes or 4 word lanes.
- R6: In 64-bit operation, `out_data[127:64]` and `out_sat[15:8]` are zero, whatever the upper operand bits hold.
- R7: No borrow crosses a lane boundary. A byte-mode result never depends on a neighbouring byte.
- R8: `out_sat[k]` is 1 exactly when the lane covering byte k was clamped. In word mode, lane j drives both bit 2j and bit 2j+1.
- R9: An accepted operation appears with `out_valid` = 1 in the cycle after the accepting edge (latency of one).
- R10: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and `out_data` and `out_sat` stay stable.
- R11: During reset and after reset, `out_valid` = 0, `out_data` = 0, `out_sat` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_opc_lsb | input | 1 | Opcode bit 0: 0 for byte lanes, 1 for word lanes |
| in_pfx_wide | input | 1 | Operand-size prefix present: 128-bit operation |
| in_a | input | 128 | Packed first operand (minuend) |
| in_b | input | 128 | Packed second operand (subtrahend) |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | 128 | Packed saturated differences |
| out_sat | output | 16 | Per-byte-position clamp indicator |

## Verification
The block holds very little state, so most faults show up in the result of the same operation, one cycle after it is accepted. A faulty lane mux or clamp bound gives a wrong byte or a wrong saturation bit in that result. A borrow that leaks between lanes corrupts the neighbouring byte of that same result. The only other state is the output register and its valid flag. A fault there shows during back-pressure: the held result changes, `in_ready` is wrong, or `out_valid` falls, in the first stalled cycle.

// File: rtl/vss_pkg.sv
package vss_pkg;
  localparam int DATA_W   = 128;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 16;
  localparam int N_BYTES  = DATA_W / BYTE_W;
  localparam int N_SLICES = DATA_W / WORD_W;
  localparam int BPS      = WORD_W / BYTE_W;

  typedef enum logic {LANE_BYTE = 1'b0, LANE_WORD = 1'b1} lane_e;
endpackage

// File: rtl/vss_clamp.sv
module vss_clamp #(
  parameter int W = 8
) (
  input  logic [W:0]   diff,
  output logic [W-1:0] q,
  output logic         hit
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    hit = diff[W] ^ diff[W-1];
    if (!hit)         q = diff[W-1:0];
    else if (diff[W]) q = MINV;
    else              q = MAXV;
  end
endmodule

// File: rtl/vss_slice.sv
module vss_slice
  import vss_pkg::*;
#(
  parameter int SW = WORD_W
) (
  input  logic [SW-1:0]  a,
  input  logic [SW-1:0]  b,
  input  lane_e          mode,
  output logic [SW-1:0]  res,
  output logic [SW/BYTE_W-1:0] sat
);
  localparam int NB = SW / BYTE_W;

  logic [SW-1:0] byte_q;
  logic [NB-1:0] byte_hit;
  logic [SW:0]   wdiff;
  logic [SW-1:0] word_q;
  logic          word_hit;

  for (genvar h = 0; h < NB; h++) begin : g_byte
    logic [BYTE_W:0] bd;
    assign bd = {a[h*BYTE_W+BYTE_W-1], a[h*BYTE_W +: BYTE_W]}
              - {b[h*BYTE_W+BYTE_W-1], b[h*BYTE_W +: BYTE_W]};
    vss_clamp #(.W(BYTE_W)) u_bclamp (
      .diff(bd), .q(byte_q[h*BYTE_W +: BYTE_W]), .hit(byte_hit[h])
    );
  end

  assign wdiff = {a[SW-1], a} - {b[SW-1], b};

  vss_clamp #(.W(SW)) u_wclamp (.diff(wdiff), .q(word_q), .hit(word_hit));

  always_comb begin
    if (mode == LANE_WORD) begin
      res = word_q;
      sat = {NB{word_hit}};
    end else begin
      res = byte_q;
      sat = byte_hit;
    end
  end

  // Unclamped lanes must carry the plain wrapped difference
  always_comb begin
    if (mode == LANE_BYTE && !sat[0])
      assert_byte_exact_R1: assert (res[BYTE_W-1:0] == BYTE_W'(a[BYTE_W-1:0] - b[BYTE_W-1:0]));
    if (mode == LANE_WORD && !sat[0])
      assert_word_exact_R4: assert (res == SW'(a - b));
  end
endmodule

// File: rtl/vss_pipe.sv
module vss_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/vsub_sat.sv
module vsub_sat
  import vss_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_opc_lsb,
  input  logic                in_pfx_wide,
  input  logic [DATA_W-1:0]   in_a,
  input  logic [DATA_W-1:0]   in_b,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic [N_BYTES-1:0]  out_sat
);
  localparam int PW = DATA_W + N_BYTES;

  lane_e               mode;
  logic                wide;
  logic [DATA_W-1:0]   res;
  logic [N_BYTES-1:0]  sat;
  logic [PW-1:0]       pay_q;

  assign mode = in_opc_lsb ? LANE_WORD : LANE_BYTE;
  assign wide = in_pfx_wide;

  for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
    logic [WORD_W-1:0] r;
    logic [BPS-1:0]    f;
    vss_slice #(.SW(WORD_W)) u_slice (
      .a(in_a[s*WORD_W +: WORD_W]), .b(in_b[s*WORD_W +: WORD_W]),
      .mode(mode), .res(r), .sat(f)
    );
    if (s >= N_SLICES/2) begin : g_upper
      assign res[s*WORD_W +: WORD_W] = wide ? r : '0;
      assign sat[s*BPS +: BPS]       = wide ? f : '0;
    end else begin : g_lower
      assign res[s*WORD_W +: WORD_W] = r;
      assign sat[s*BPS +: BPS]       = f;
    end
  end

  vss_pipe #(.W(PW)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data({sat, res}),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(pay_q)
  );

  assign out_data = pay_q[DATA_W-1:0];
  assign out_sat  = pay_q[PW-1:DATA_W];

  assert_narrow_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_pfx_wide) |=>
      (out_data[DATA_W-1:DATA_W/2] == '0 && out_sat[N_BYTES-1:N_BYTES/2] == '0));
endmodule

// File: tb/vsub_sat_test.sv
`timescale 1ns/1ps
module vsub_sat_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_opc_lsb = 1'b0;
  logic         in_pfx_wide = 1'b1;
  logic [127:0] in_a = '0;
  logic [127:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic [15:0]  out_sat;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  vsub_sat uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opc_lsb(in_opc_lsb), .in_pfx_wide(in_pfx_wide), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sat(out_sat)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int clampv(input int d, input int lo, input int hi);
    if (d > hi) return hi;
    if (d < lo) return lo;
    return d;
  endfunction

  function automatic logic [127:0] exp_data(input logic [127:0] a, b, input logic word, wide);
    logic [127:0] r = '0;
    if (word) begin
      for (int i = 0; i < (wide ? 8 : 4); i++) begin
        int d = int'($signed(a[i*16 +: 16])) - int'($signed(b[i*16 +: 16]));
        int c = clampv(d, -32768, 32767);
        r[i*16 +: 16] = c[15:0];
      end
    end else begin
      for (int i = 0; i < (wide ? 16 : 8); i++) begin
        int d = int'($signed(a[i*8 +: 8])) - int'($signed(b[i*8 +: 8]));
        int c = clampv(d, -128, 127);
        r[i*8 +: 8] = c[7:0];
      end
    end
    return r;
  endfunction

  function automatic logic [15:0] exp_sat(input logic [127:0] a, b, input logic word, wide);
    logic [15:0] s = '0;
    if (word) begin
      for (int i = 0; i < (wide ? 8 : 4); i++) begin
        int d = int'($signed(a[i*16 +: 16])) - int'($signed(b[i*16 +: 16]));
        if (d > 32767 || d < -32768) s[2*i +: 2] = 2'b11;
      end
    end else begin
      for (int i = 0; i < (wide ? 16 : 8); i++) begin
        int d = int'($signed(a[i*8 +: 8])) - int'($signed(b[i*8 +: 8]));
        if (d > 127 || d < -128) s[i] = 1'b1;
      end
    end
    return s;
  endfunction

  task automatic chk(input string tag, input string what, input logic [127:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // one operation with the output drained every cycle
  task automatic run_op(input logic [127:0] a, b, input logic word, wide, input string tag);
    @(negedge clk);
    in_a = a; in_b = b; in_opc_lsb = word; in_pfx_wide = wide;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "out_valid", 128'(out_valid), 128'd1);
    chk(tag, "data", out_data, exp_data(a, b, word, wide));
    chk("R8", "sat", 128'(out_sat), 128'(exp_sat(a, b, word, wide)));
  endtask

  function automatic logic [15:0] wval(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;  3: return 16'h7FFE;
      4: return 16'h7FFF;  5: return 16'h8000;  6: return 16'h8001;  7: return 16'hFFFF;
      8: return 16'hFFFE;  9: return 16'h4000; 10: return 16'hC000; 11: return 16'h1234;
      12: return 16'hABCD; 13: return 16'h00FF; 14: return 16'hFF00; default: return 16'h3FFF;
    endcase
  endfunction

  initial begin
    logic [127:0] a, b, ha, hb;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "out_valid", 128'(out_valid), 128'd0);
    chk("R11", "in_ready", 128'(in_ready), 128'd1);
    chk("R11", "data", out_data, 128'd0);
    chk("R11", "sat", 128'(out_sat), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "out_valid after reset", 128'(out_valid), 128'd0);

    // R2 / R3 / R1 directed byte lanes
    run_op({16{8'h7F}}, {16{8'hFF}}, 1'b0, 1'b1, "R2");
    chk("R2", "lane0", 128'(out_data[7:0]), 128'h7F);
    run_op({16{8'h80}}, {16{8'h01}}, 1'b0, 1'b1, "R3");
    chk("R3", "lane15", 128'(out_data[127:120]), 128'h80);
    run_op({16{8'h05}}, {16{8'h07}}, 1'b0, 1'b1, "R1");
    chk("R1", "lane3", 128'(out_data[31:24]), 128'hFE);

    // R7: borrows stay inside byte lanes
    run_op({8{16'h0100}}, {8{16'h0001}}, 1'b0, 1'b1, "R7");
    chk("R7", "no borrow", 128'(out_data[15:0]), 128'h01FF);
    run_op({8{16'h8000}}, {8{16'h0001}}, 1'b0, 1'b1, "R7");
    chk("R7", "no borrow high", 128'(out_data[15:0]), 128'h80FF);

    // R4 / R5: word form chosen by opcode bit
    run_op({8{16'h7FFF}}, {8{16'hFFFF}}, 1'b1, 1'b1, "R4");
    chk("R4", "word max", 128'(out_data[15:0]), 128'h7FFF);
    run_op({8{16'h8000}}, {8{16'h0001}}, 1'b1, 1'b1, "R4");
    chk("R4", "word min", 128'(out_data[127:112]), 128'h8000);
    run_op({8{16'h0100}}, {8{16'h0001}}, 1'b1, 1'b1, "R5");
    chk("R5", "word lanes", 128'(out_data[15:0]), 128'h00FF);

    // R6: narrow form ignores the upper half
    run_op({128{1'b1}} ^ 128'h1, {16{8'h80}}, 1'b0, 1'b0, "R6");
    chk("R6", "upper data", out_data[127:64], 128'd0);
    chk("R6", "upper sat", 128'(out_sat[15:8]), 128'd0);
    run_op({8{16'h8000}}, {8{16'h7FFF}}, 1'b1, 1'b0, "R6");
    chk("R6", "upper word", out_data[127:64], 128'd0);

    // R1/R2/R3 exhaustive byte sweep, 128-bit form
    for (int ai = 0; ai < 256; ai++) begin
      for (int g = 0; g < 16; g++) begin
        for (int l = 0; l < 16; l++) begin
          a[l*8 +: 8] = 8'(ai);
          b[l*8 +: 8] = 8'(g*16 + l);
        end
        run_op(a, b, 1'b0, 1'b1, "R1");
      end
    end

    // R6 partial byte sweep in 64-bit form, upper halves nonzero
    for (int ai = 0; ai < 256; ai += 7) begin
      for (int l = 0; l < 16; l++) begin
        a[l*8 +: 8] = 8'(ai + l);
        b[l*8 +: 8] = 8'(255 - ai + 3*l);
      end
      run_op(a, b, 1'b0, 1'b0, "R6");
    end

    // R4 word boundary sweep, both widths
    for (int w = 0; w < 2; w++) begin
      for (int p = 0; p < 32; p++) begin
        for (int l = 0; l < 8; l++) begin
          int idx = p*8 + l;
          a[l*16 +: 16] = wval(idx / 16);
          b[l*16 +: 16] = wval(idx % 16);
        end
        run_op(a, b, 1'b1, w[0], "R4");
      end
    end

    // R10: back-pressure hold
    ha = {16{8'h10}}; hb = {16{8'h90}};
    @(negedge clk);
    out_ready = 1'b0; in_a = ha; in_b = hb; in_opc_lsb = 1'b0; in_pfx_wide = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R9", "out_valid", 128'(out_valid), 128'd1);
    chk("R10", "in_ready low", 128'(in_ready), 128'd0);
    chk("R10", "held data", out_data, exp_data(ha, hb, 1'b0, 1'b1));
    in_a = {8{16'h1234}}; in_b = {8{16'h0034}}; in_opc_lsb = 1'b1;
    @(negedge clk);
    chk("R10", "held data 2", out_data, exp_data(ha, hb, 1'b0, 1'b1));
    chk("R10", "held sat", 128'(out_sat), 128'(exp_sat(ha, hb, 1'b0, 1'b1)));
    @(negedge clk);
    chk("R10", "held data 3", out_data, exp_data(ha, hb, 1'b0, 1'b1));
    chk("R10", "valid held", 128'(out_valid), 128'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "next data", out_data, {8{16'h1200}});
    chk("R10", "next valid", 128'(out_valid), 128'd1);
    @(negedge clk);
    chk("R9", "drained", 128'(out_valid), 128'd0);
    chk("R10", "in_ready idle", 128'(in_ready), 128'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule